// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the command-decoding front end of a parallel NOR flash that follows the classic two-cycle write-command protocol. A host on a simple synchronous bus slave port writes command bytes and data, and reads back array contents, the status byte, identification codes or query-table bytes, depending on the command currently latched. A small register-based byte array stands in for the flash cells. Programming and erasing complete instantly; there is no cell timing model.

The sequencer tracks a write phase (command, argument, buffered data, confirm), the latched command and an 8-bit status byte. It handles single-word program, sector erase, buffered multi-word write with a word count and a confirm step, status clear, lock/unlock acknowledgement, identification and query modes, and return to array reads. A write-protect input turns program and erase into error reports. An optional secure mode rejects untrusted writes and lets untrusted reads see only the array. A build parameter selects big- or little-endian byte order for multi-byte array accesses.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset the phase is idle, no command is latched, the status byte is 0x00 and every array byte reads 0xFF.
- R2: In the idle phase, the command bytes 0x00, 0xF0 and 0xFF, and any byte that is not a known command, return the block to array reads with phase and command cleared.
- R3: Command 0x10 or 0x40 makes the next write store its data at its address with its access width. Status bit 7 (ready, 0x80) is then set and the phase returns to idle.
- R4: Command 0x20 at once fills the sector holding the address, aligned down to SECTOR_BYTES, with 0xFF and sets status bit 7. A following 0xD0 completes the sequence and sets bit 7. A following 0xFF returns to array reads. Any other byte also returns to array reads.
- R5: While wr_protect is high, a program leaves the array unchanged and sets status bit 4 (0x10). An erase leaves the array unchanged and sets status bit 5 (0x20). Both still set bit 7.
- R6: Command 0xE8 sets status bit 7. The next write gives a word count masked to the low 8*DEV_BYTES bits. A count of N accepts N+1 data writes, and each is stored. The block then waits in a confirm phase, where 0xD0 completes the sequence and any other byte returns to array reads.
- R7: While the latched command is 0x10, 0x20, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read returns the status byte in the low byte of every DEV_BYTES-wide device slot within the access width. Other bits are zero.
- R8: Command 0x50 clears the status byte to 0x00 and returns to array reads.
- R9: After 0x60, a write of 0xD0 or 0x01 sets status bit 7 and returns to idle. Any other byte returns to array reads.
- R10: Under 0x90, read word index (address >> log2 BUS_BYTES) 0 gives MFR_ID and index 1 gives DEV_ID. Any other index gives 0. Each value is repeated per device. Under 0x98, indexes 0x10, 0x11 and 0x12 give 0x51, 0x52 and 0x59, index 0x13 gives 0x01, index 0x2C gives 0x01 and index 0x27 gives log2 of the per-device byte count. Every other index gives 0. Writes other than 0xFF keep query mode, and 0xFF leaves it.
- R11: With SECURE_EN set, a write with bus_secure low is ignored and raises bus_err. A read with bus_secure low returns array data whatever command is latched.
- R12: Multi-byte array accesses place the byte at the lowest address in the least significant lane when BIG_END is 0, and in the most significant lane of the access width when BIG_END is 1.
- R13: bus_size encodes 0 = byte, 1 = halfword, 2 = word. The code 3 is illegal: such a write is ignored, and a read returns 0. Either access raises bus_err.
- R14: bus_rdata and bus_err are registered. They reflect an access one clock after the strobe, and bus_rdata is zero in a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8*BUS_BYTES | Write data; command byte in bits 7:0 |
| bus_size | input | 2 | Access width code |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_secure | input | 1 | Access is trusted |
| wr_protect | input | 1 | Whole array is read-only |
| bus_rdata | output | 8*BUS_BYTES | Registered read data |
| bus_err | output | 1 | Registered bus error |

## Verification
Every write updates phase, command, status and array on the clock edge where its strobe is sampled. Any read, including one in the cycle just after a write, sees the new state. The read result and the error flag appear in the register one edge after their strobe. The bench drives each strobe at a falling edge for one cycle and samples bus_rdata and bus_err at the next falling edge, which is exactly one rising edge later. Each command sequence is then checked through reads in the following cycles.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARG  = 2'd1,
        PH_DATA = 2'd2,
        PH_CONF = 2'd3
    } phase_e;

    typedef struct packed {
        logic store;
        logic wipe;
    } array_ctl_t;

    localparam logic [7:0] OP_NONE     = 8'h00;
    localparam logic [7:0] OP_LOCK_ALT = 8'h01;
    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_CLEAR    = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_BUFWR    = 8'hE8;
    localparam logic [7:0] OP_ARRAY    = 8'hFF;

    localparam int ST_READY     = 7;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_PROG_ERR  = 4;

    function automatic logic [3:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            2'd2:    return 4'd4;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic is_status_op(input logic [7:0] op);
        return (op == OP_PROG_A) || (op == OP_PROG_B) || (op == OP_ERASE) ||
               (op == OP_CLEAR)  || (op == OP_LOCK)   || (op == OP_STATUS) ||
               (op == OP_BUFWR);
    endfunction

    function automatic logic [7:0] query_byte(input logic [7:0] idx, input logic [7:0] dev_log2);
        case (idx)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            8'h13:   return 8'h01;
            8'h27:   return dev_log2;
            8'h2C:   return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nor_cell_array.sv
module nor_cell_array
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int BUS_BYTES    = 4,
    parameter int SECTOR_BYTES = 64,
    parameter bit BIG_END      = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  array_ctl_t             ctl,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [3:0]             nbytes,
    input  logic [8*BUS_BYTES-1:0] wdata,
    output logic [8*BUS_BYTES-1:0] rdata
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int SECT_SHIFT = $clog2(SECTOR_BYTES);

    logic [7:0]        cells     [DEPTH];
    logic [ADDR_W-1:0] lane_addr [BUS_BYTES];
    logic [7:0]        lane_byte [BUS_BYTES];
    logic              lane_on   [BUS_BYTES];
    int                nb;

    // Per-lane address and write byte; lane order follows BIG_END.
    always_comb begin
        nb = int'(nbytes);
        for (int k = 0; k < BUS_BYTES; k++) begin
            lane_addr[k] = addr + ADDR_W'(k);
            lane_on[k]   = (k < nb);
            lane_byte[k] = 8'h00;
            if (k < nb) begin
                if (BIG_END) lane_byte[k] = wdata[8*(nb-1-k) +: 8];
                else         lane_byte[k] = wdata[8*k +: 8];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < BUS_BYTES; k++) begin
            if (k < nb) begin
                if (BIG_END) rdata[8*(nb-1-k) +: 8] = cells[lane_addr[k]];
                else         rdata[8*k +: 8]        = cells[lane_addr[k]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else begin
            if (ctl.wipe) begin
                for (int i = 0; i < DEPTH; i++)
                    if ((i >> SECT_SHIFT) == int'(addr >> SECT_SHIFT))
                        cells[i] <= 8'hFF;
            end
            if (ctl.store) begin
                for (int k = 0; k < BUS_BYTES; k++)
                    if (lane_on[k]) cells[lane_addr[k]] <= lane_byte[k];
            end
        end
    end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  logic [7:0]       op_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             protect,
    output phase_e           phase_q,
    output logic [7:0]       op_q,
    output logic [7:0]       status_q,
    output array_ctl_t       ctl
);
    phase_e           phase_n;
    logic [7:0]       op_n;
    logic [7:0]       status_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        phase_n   = phase_q;
        op_n      = op_q;
        status_n  = status_q;
        cnt_n     = cnt_q;
        ctl.store = 1'b0;
        ctl.wipe  = 1'b0;
        if (wr_go) begin
            case (phase_q)
                PH_IDLE: begin
                    case (op_in)
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                            phase_n = PH_ARG;
                            op_n    = op_in;
                        end
                        OP_ERASE: begin
                            if (protect) status_n[ST_ERASE_ERR] = 1'b1;
                            else         ctl.wipe = 1'b1;
                            status_n[ST_READY] = 1'b1;
                            phase_n = PH_ARG;
                            op_n    = op_in;
                        end
                        OP_BUFWR: begin
                            status_n[ST_READY] = 1'b1;
                            phase_n = PH_ARG;
                            op_n    = op_in;
                        end
                        OP_STATUS, OP_IDENT: op_n = op_in;
                        OP_CLEAR: begin
                            status_n = 8'h00;
                            op_n     = OP_NONE;
                        end
                        default: op_n = OP_NONE;
                    endcase
                end
                PH_ARG: begin
                    case (op_q)
                        OP_PROG_A, OP_PROG_B: begin
                            if (protect) status_n[ST_PROG_ERR] = 1'b1;
                            else         ctl.store = 1'b1;
                            status_n[ST_READY] = 1'b1;
                            phase_n = PH_IDLE;
                        end
                        OP_ERASE: begin
                            phase_n = PH_IDLE;
                            if (op_in == OP_CONFIRM) status_n[ST_READY] = 1'b1;
                            else                     op_n = OP_NONE;
                        end
                        OP_LOCK: begin
                            phase_n = PH_IDLE;
                            if (op_in == OP_CONFIRM || op_in == OP_LOCK_ALT)
                                status_n[ST_READY] = 1'b1;
                            else
                                op_n = OP_NONE;
                        end
                        OP_BUFWR: begin
                            cnt_n   = cnt_in;
                            phase_n = PH_DATA;
                        end
                        OP_QUERY: begin
                            if (op_in == OP_ARRAY) begin
                                phase_n = PH_IDLE;
                                op_n    = OP_NONE;
                            end
                        end
                        default: begin
                            phase_n = PH_IDLE;
                            op_n    = OP_NONE;
                        end
                    endcase
                end
                PH_DATA: begin
                    if (protect) status_n[ST_PROG_ERR] = 1'b1;
                    else         ctl.store = 1'b1;
                    status_n[ST_READY] = 1'b1;
                    if (cnt_q == '0) phase_n = PH_CONF;
                    cnt_n = cnt_q - CNT_W'(1);
                end
                default: begin
                    phase_n = PH_IDLE;
                    if (op_in == OP_CONFIRM) status_n[ST_READY] = 1'b1;
                    else                     op_n = OP_NONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            op_q     <= OP_NONE;
            status_q <= 8'h00;
            cnt_q    <= '0;
        end else begin
            phase_q  <= phase_n;
            op_q     <= op_n;
            status_q <= status_n;
            cnt_q    <= cnt_n;
        end
    end

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
    import nor_seq_pkg::*;
#(
    parameter int                   ADDR_W       = 8,
    parameter int                   BUS_BYTES    = 4,
    parameter int                   DEV_BYTES    = 1,
    parameter int                   SECTOR_BYTES = 64,
    parameter bit                   BIG_END      = 1'b0,
    parameter bit                   SECURE_EN    = 1'b1,
    parameter logic [8*DEV_BYTES-1:0] MFR_ID     = 8'h89,
    parameter logic [8*DEV_BYTES-1:0] DEV_ID     = 8'h18
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [8*BUS_BYTES-1:0] bus_wdata,
    input  logic [1:0]             bus_size,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic                   bus_secure,
    input  logic                   wr_protect,
    output logic [8*BUS_BYTES-1:0] bus_rdata,
    output logic                   bus_err
);
    localparam int DW         = 8 * BUS_BYTES;
    localparam int CNT_W      = 8 * DEV_BYTES;
    localparam int BANK_SHIFT = $clog2(BUS_BYTES);
    localparam logic [7:0] DEV_LOG2 = 8'(ADDR_W - $clog2(BUS_BYTES / DEV_BYTES));

    logic [3:0]        nbytes;
    logic              size_ok, trusted, wr_go;
    logic [ADDR_W-1:0] word_idx;
    logic [DW-1:0]     arr_rdata, rd_next;
    logic [CNT_W-1:0]  id_val;
    logic [7:0]        qry_val;
    phase_e            phase_q;
    logic [7:0]        op_q, status_q;
    array_ctl_t        arr_ctl;
    int                nb;

    assign nbytes   = size_bytes(bus_size);
    assign nb       = int'(nbytes);
    assign size_ok  = (nbytes != 4'd0) && (nb <= BUS_BYTES);
    assign trusted  = !SECURE_EN || bus_secure;
    assign wr_go    = bus_wr && size_ok && trusted;
    assign word_idx = bus_addr >> BANK_SHIFT;

    nor_cmd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (wr_go),
        .op_in    (bus_wdata[7:0]),
        .cnt_in   (bus_wdata[CNT_W-1:0]),
        .protect  (wr_protect),
        .phase_q  (phase_q),
        .op_q     (op_q),
        .status_q (status_q),
        .ctl      (arr_ctl)
    );

    nor_cell_array #(
        .ADDR_W       (ADDR_W),
        .BUS_BYTES    (BUS_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .BIG_END      (BIG_END)
    ) u_cells (
        .clk    (clk),
        .rst    (rst),
        .ctl    (arr_ctl),
        .addr   (bus_addr),
        .nbytes (nbytes),
        .wdata  (bus_wdata),
        .rdata  (arr_rdata)
    );

    always_comb begin
        id_val  = (word_idx == ADDR_W'(0)) ? MFR_ID :
                  (word_idx == ADDR_W'(1)) ? DEV_ID : '0;
        qry_val = query_byte(8'(word_idx), DEV_LOG2);
        rd_next = '0;
        if (!size_ok) begin
            rd_next = '0;
        end else if (!trusted || op_q == OP_NONE) begin
            rd_next = arr_rdata;
        end else if (is_status_op(op_q)) begin
            for (int k = 0; k < BUS_BYTES; k++)
                if (k < nb && (k % DEV_BYTES) == 0) rd_next[8*k +: 8] = status_q;
        end else if (op_q == OP_IDENT) begin
            for (int k = 0; k < BUS_BYTES; k++)
                if (k < nb) rd_next[8*k +: 8] = id_val[8*(k % DEV_BYTES) +: 8];
        end else if (op_q == OP_QUERY) begin
            for (int k = 0; k < BUS_BYTES; k++)
                if (k < nb && (k % DEV_BYTES) == 0) rd_next[8*k +: 8] = qry_val;
        end else begin
            rd_next = arr_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_next : '0;
            bus_err   <= (bus_wr && (!size_ok || !trusted)) || (bus_rd && !size_ok);
        end
    end

endmodule

// File: rtl/nor_seq_checks.sv
module nor_seq_checks #(
    parameter bit SEC_ON = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       wr,
    input logic       secure,
    input logic [1:0] size,
    input logic [7:0] op_in,
    input logic       err,
    input logic [1:0] phase,
    input logic [7:0] op,
    input logic [7:0] status
);
    logic legal_wr;
    assign legal_wr = wr && (size != 2'd3) && (secure || !SEC_ON);

    // R11: untrusted write answered with a bus error
    a_r11_untrusted_write_err: assert property (@(posedge clk) disable iff (rst)
        (wr && !secure && SEC_ON) |=> err);

    // R13: illegal width flags an error and leaves the phase alone
    a_r13_bad_size_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && size == 2'd3) |=> (err && phase == $past(phase)));

    // R8: clear-status empties status and command
    a_r8_clear_status: assert property (@(posedge clk) disable iff (rst)
        (legal_wr && phase == 2'd0 && op_in == 8'h50) |=> (status == 8'h00 && op == 8'h00));

    // R2: array command drops back to read-array
    a_r2_array_exit: assert property (@(posedge clk) disable iff (rst)
        (legal_wr && phase == 2'd0 && op_in == 8'hFF) |=> (phase == 2'd0 && op == 8'h00));

    // R3: program data write ends with ready and idle phase
    a_r3_program_ready: assert property (@(posedge clk) disable iff (rst)
        (legal_wr && phase == 2'd1 && (op == 8'h10 || op == 8'h40)) |=> (status[7] && phase == 2'd0));

    // R6: confirm phase only follows buffered data
    a_r6_confirm_entry: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3) |-> ($past(phase) == 2'd2 || $past(phase) == 2'd3));

endmodule

bind nor_cmd_sequencer nor_seq_checks #(.SEC_ON(SECURE_EN)) u_seq_checks (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr),
    .secure (bus_secure),
    .size   (bus_size),
    .op_in  (bus_wdata[7:0]),
    .err    (bus_err),
    .phase  (phase_q),
    .op     (op_q),
    .status (status_q)
);

// File: tb/test_nor_cmd_sequencer.sv
module test_nor_cmd_sequencer;

    localparam logic [1:0] SZ_B = 2'd0;
    localparam logic [1:0] SZ_H = 2'd1;
    localparam logic [1:0] SZ_W = 2'd2;
    localparam logic [1:0] SZ_X = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = SZ_W;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_secure = 1'b1;
    logic        wr_protect = 1'b0;
    logic [31:0] rdata_le, rdata_be;
    logic        err_le, err_be;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] got, got_be;
    logic        got_err, w_err;

    always #5 clk = ~clk;

    nor_cmd_sequencer i_nor_cmd_sequencer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_secure(bus_secure), .wr_protect(wr_protect),
        .bus_rdata(rdata_le), .bus_err(err_le)
    );

    nor_cmd_sequencer #(.BIG_END(1'b1)) i_nor_cmd_sequencer_be (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_secure(bus_secure), .wr_protect(wr_protect),
        .bus_rdata(rdata_be), .bus_err(err_be)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        w_err  = err_le;
    endtask

    task automatic cmd(input logic [7:0] a, input logic [7:0] op);
        wr(a, {24'h0, op}, SZ_B);
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd  = 1'b0;
        got     = rdata_le;
        got_be  = rdata_be;
        got_err = err_le;
    endtask

    task automatic t_reset;
        rd(8'h00, SZ_W); check("R1 erased array after reset", got, 32'hFFFFFFFF);
        rd(8'hFC, SZ_W); check("R1 top word after reset", got, 32'hFFFFFFFF);
        cmd(8'h00, 8'h70);
        rd(8'h00, SZ_B); check("R1 status zero after reset", got, 32'h0);
        cmd(8'h00, 8'hFF);
        @(negedge clk); check("R14 rdata idle without read", rdata_le, 32'h0);
    endtask

    task automatic t_program;
        cmd(8'h10, 8'h40);
        wr(8'h10, 32'h11223344, SZ_W);
        check("R14 no error on legal write", {31'h0, w_err}, 32'h0);
        rd(8'h10, SZ_W); check("R7 status replicated on word", got, 32'h80808080);
        rd(8'h10, SZ_H); check("R7 status replicated on halfword", got, 32'h00008080);
        cmd(8'h00, 8'hFF);
        rd(8'h10, SZ_W); check("R3 programmed word", got, 32'h11223344);
        rd(8'h11, SZ_B); check("R12 little-endian byte", got, 32'h33);
        check("R12 big-endian byte", got_be, 32'h22);
        rd(8'h12, SZ_H); check("R12 little-endian half", got, 32'h1122);
        check("R12 big-endian half", got_be, 32'h3344);
        cmd(8'h05, 8'h10);
        wr(8'h05, 32'hA5, SZ_B);
        cmd(8'h00, 8'hFF);
        rd(8'h05, SZ_B); check("R3 byte program via 0x10", got, 32'hA5);
        rd(8'h04, SZ_W); check("R3 neighbours untouched", got, 32'hFFFFA5FF);
    endtask

    task automatic t_erase;
        cmd(8'h44, 8'h40); wr(8'h44, 32'hDEADBEEF, SZ_W); cmd(8'h00, 8'hFF);
        cmd(8'h80, 8'h40); wr(8'h80, 32'h5A, SZ_B); cmd(8'h00, 8'hFF);
        cmd(8'h5C, 8'h20);
        rd(8'h00, SZ_B); check("R4 ready after erase command", got, 32'h80);
        cmd(8'h00, 8'hD0);
        rd(8'h00, SZ_B); check("R4 ready after confirm", got, 32'h80);
        cmd(8'h00, 8'hFF);
        rd(8'h44, SZ_W); check("R4 sector wiped", got, 32'hFFFFFFFF);
        rd(8'h80, SZ_B); check("R4 next sector kept", got, 32'h5A);
        rd(8'h10, SZ_W); check("R4 previous sector kept", got, 32'h11223344);
        cmd(8'h85, 8'h20);
        cmd(8'h00, 8'hFF);
        rd(8'h80, SZ_B); check("R4 erase then 0xFF reads array", got, 32'hFF);
    endtask

    task automatic t_clear;
        cmd(8'h00, 8'h70);
        rd(8'h00, SZ_B); check("R8 status before clear", got, 32'h80);
        cmd(8'h00, 8'h50);
        rd(8'h10, SZ_W); check("R8 clear returns to array", got, 32'h11223344);
        cmd(8'h00, 8'h70);
        rd(8'h00, SZ_B); check("R8 status cleared", got, 32'h00);
        cmd(8'h00, 8'hFF);
    endtask

    task automatic t_readonly;
        wr_protect = 1'b1;
        cmd(8'h20, 8'h40);
        wr(8'h20, 32'h12345678, SZ_W);
        rd(8'h00, SZ_B); check("R5 program error bit", got, 32'h90);
        cmd(8'h00, 8'hFF);
        rd(8'h20, SZ_W); check("R5 protected program no store", got, 32'hFFFFFFFF);
        cmd(8'h00, 8'h50);
        cmd(8'h10, 8'h20);
        rd(8'h00, SZ_B); check("R5 erase error bit", got, 32'hA0);
        cmd(8'h00, 8'hD0);
        cmd(8'h00, 8'hFF);
        rd(8'h10, SZ_W); check("R5 protected erase no wipe", got, 32'h11223344);
        wr_protect = 1'b0;
        cmd(8'h00, 8'h50);
    endtask

    task automatic t_buffer;
        cmd(8'h90, 8'hE8);
        rd(8'h00, SZ_B); check("R6 ready after buffer command", got, 32'h80);
        wr(8'h90, 32'h00000102, SZ_W);
        wr(8'h90, 32'hA0A1A2A3, SZ_W);
        wr(8'h94, 32'hB0B1B2B3, SZ_W);
        wr(8'h98, 32'hC0C1C2C3, SZ_W);
        rd(8'h00, SZ_W); check("R7 status in confirm phase", got, 32'h80808080);
        wr(8'h9C, 32'h000000D0, SZ_W);
        cmd(8'h00, 8'hFF);
        rd(8'h90, SZ_W); check("R6 buffered word 0", got, 32'hA0A1A2A3);
        rd(8'h94, SZ_W); check("R6 buffered word 1", got, 32'hB0B1B2B3);
        rd(8'h98, SZ_W); check("R6 buffered word 2", got, 32'hC0C1C2C3);
        rd(8'h9C, SZ_W); check("R6 count masked, confirm not stored", got, 32'hFFFFFFFF);
        cmd(8'hA0, 8'hE8);
        wr(8'hA0, 32'h0, SZ_W);
        wr(8'hA0, 32'h01020304, SZ_W);
        cmd(8'hA4, 8'h55);
        rd(8'hA0, SZ_W); check("R6 bad confirm returns to array", got, 32'h01020304);
        rd(8'hA4, SZ_W); check("R6 zero count takes one word", got, 32'hFFFFFFFF);
    endtask

    task automatic t_lock;
        cmd(8'h00, 8'h50);
        cmd(8'h00, 8'h60); cmd(8'h00, 8'h01);
        rd(8'h00, SZ_B); check("R9 lock completes with 0x01", got, 32'h80);
        cmd(8'h00, 8'hFF);
        cmd(8'h00, 8'h50);
        cmd(8'h00, 8'h60); cmd(8'h00, 8'hD0);
        rd(8'h00, SZ_B); check("R9 lock completes with 0xD0", got, 32'h80);
        cmd(8'h00, 8'h60); cmd(8'h00, 8'h33);
        rd(8'h10, SZ_W); check("R9 other byte returns to array", got, 32'h11223344);
    endtask

    task automatic t_modes;
        logic [7:0] ops [4];
        ops[0] = 8'h00; ops[1] = 8'hF0; ops[2] = 8'hFF; ops[3] = 8'h3C;
        for (int i = 0; i < 4; i++) begin
            cmd(8'h00, 8'h70);
            cmd(8'h00, ops[i]);
            rd(8'h10, SZ_W); check($sformatf("R2 byte %h reads array", ops[i]), got, 32'h11223344);
        end
    endtask

    task automatic t_ident;
        cmd(8'h00, 8'h90);
        rd(8'h00, SZ_W); check("R10 maker code", got, 32'h89898989);
        rd(8'h04, SZ_W); check("R10 device code", got, 32'h18181818);
        rd(8'h08, SZ_W); check("R10 other index zero", got, 32'h0);
        cmd(8'h00, 8'hFF);
        cmd(8'h00, 8'h98);
        rd(8'h40, SZ_B); check("R10 query Q", got, 32'h51);
        rd(8'h44, SZ_W); check("R10 query R", got, 32'h52525252);
        rd(8'h48, SZ_W); check("R10 query Y", got, 32'h59595959);
        rd(8'h4C, SZ_W); check("R10 query command set", got, 32'h01010101);
        rd(8'h50, SZ_W); check("R10 query blank index", got, 32'h0);
        cmd(8'h00, 8'h00);
        rd(8'h40, SZ_B); check("R10 query kept after non-0xFF", got, 32'h51);
        cmd(8'h00, 8'hFF);
        rd(8'h40, SZ_W); check("R10 0xFF leaves query", got, 32'hFFFFFFFF);
    endtask

    task automatic t_secure;
        bus_secure = 1'b0;
        cmd(8'h00, 8'h70);
        check("R11 untrusted write error", {31'h0, w_err}, 32'h1);
        bus_secure = 1'b1;
        rd(8'h10, SZ_W); check("R11 untrusted write ignored", got, 32'h11223344);
        cmd(8'h00, 8'h70);
        bus_secure = 1'b0;
        rd(8'h10, SZ_W); check("R11 untrusted read sees array", got, 32'h11223344);
        check("R11 untrusted read no error", {31'h0, got_err}, 32'h0);
        bus_secure = 1'b1;
        rd(8'h10, SZ_W); check("R11 trusted read sees status", got, 32'h80808080);
        cmd(8'h00, 8'hFF);
    endtask

    task automatic t_illegal;
        wr(8'h00, 32'h70, SZ_X);
        check("R13 illegal write error", {31'h0, w_err}, 32'h1);
        rd(8'h10, SZ_W); check("R13 illegal write ignored", got, 32'h11223344);
        rd(8'h10, SZ_X);
        check("R13 illegal read data", got, 32'h0);
        check("R13 illegal read error", {31'h0, got_err}, 32'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_erase();
        t_clear();
        t_readonly();
        t_buffer();
        t_lock();
        t_modes();
        t_ident();
        t_secure();
        t_illegal();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule